// File: doc/BRIEF.md
# Multiprocessor-Addressed Serial Receiver

This block receives asynchronous serial characters for a node on a line that several processors share. A free-running oversampling tick, sixteen pulses per bit, paces all sampling. A byte-wide control register switches the receiver on, picks 7 or 8 data bits and one or two stop bits, and arms a wakeup filter. Each finished character goes to a one-deep holding register. A full flag marks the held byte, and a read strobe empties the register.

When the multiprocessor-format input is high, every character carries one extra marker bit between the last data bit and the stop bit(s). With the wakeup filter armed, a character whose marker bit is 0 is thrown away before it can touch the full flag, the held byte or either error flag. A node can therefore sleep through traffic meant for other nodes and wake only on address characters. Bit 3 of the control register reads back the marker bit of the last accepted character. Writing 0 to that bit clears the error flags.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset the control register reads 0x10, and rx_full, err_frame and err_overrun are all 0.
- R2: A frame is a low start bit, then the data bits LSB first (8 bits when control bit 2 is 1, else 7), then the marker bit only when mp_sel is 1, then one stop bit (two when control bit 0 is 1). Each bit lasts 16 os_tick pulses. An accepted character sets rx_full and appears on rx_data. In 7-bit format rx_data bit 7 is 0.
- R3: A start bit that is no longer low at its middle (8 ticks after the falling edge is seen) is rejected, and no character is received.
- R4: With mp_sel at 0, control bit 7 (wakeup enable) has no effect, and every character is accepted.
- R5: With mp_sel at 1 and control bit 7 at 1, a character whose marker bit is 0 changes none of rx_full, rx_data, err_frame and err_overrun, even if its stop bit is low.
- R6: With mp_sel at 1 and control bit 7 at 0, every character is accepted whatever its marker bit is.
- R7: Writes store control bits 7..4 and 2..0, and those bits read back. Bit 3 reads the marker bit of the last accepted character, or 0 if that character had no marker bit.
- R8: An accepted character that has a low stop bit sets err_frame. The byte is still loaded.
- R9: An accepted character that completes while rx_full is 1 sets err_overrun and leaves rx_data unchanged.
- R10: A control write with bit 3 at 0 clears err_frame and err_overrun. A write with bit 3 at 1 leaves them as they are.
- R11: While control bit 6 (receiver enable) is 0, the receiver aborts any frame in progress and receives nothing. After it is enabled again, it receives the next frame correctly.
- R12: A pulse on rx_rd clears rx_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rxd | input | 1 | Serial input line, idle high |
| mp_sel | input | 1 | Selects multiprocessor frame format with a marker bit |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Control register read value |
| rx_rd | input | 1 | Read strobe that empties the holding register |
| rx_data | output | 8 | Held received character |
| rx_full | output | 1 | Holding register contains an unread character |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Overrun error flag |

## Verification
A bit counter or shift alignment that is off by one shows up at the ports as soon as the first frame ends. rx_data comes out shifted, or the marker bit read back through control bit 3 is wrong. The wakeup filter is checked with a dropped frame whose stop bit is also bad. If the filter decides too late, err_frame shows it within one cycle of the frame ending. A sampler stuck outside idle after the receiver is disabled shows up as a missed or garbled character on the first frame after it is enabled again.

// File: rtl/mpurx_pkg.sv
package mpurx_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  // control register bit positions
  localparam int unsigned CB_WAKE  = 7;
  localparam int unsigned CB_RXEN  = 6;
  localparam int unsigned CB_MARK  = 3;
  localparam int unsigned CB_LEN8  = 2;
  localparam int unsigned CB_STOP2 = 0;
endpackage

// File: rtl/mpurx_sampler.sv
module mpurx_sampler
  import mpurx_pkg::*;
#(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          en,
  input  logic          len8,
  input  logic          mp_fmt,
  input  logic          two_stop,
  output logic          done,
  output logic [DW-1:0] word,
  output logic          mpbit,
  output logic          stop_ok
);
  localparam int SHW = DW + 1;
  localparam int CW  = $clog2(OS);
  localparam int BW  = $clog2(SHW + 1);
  localparam int MID = OS / 2 - 1;

  logic [1:0]     sync_q;
  logic           rx_s;
  rx_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [BW-1:0]  bcnt_q, bcnt_d;
  logic [SHW-1:0] sreg_q, sreg_d;
  logic           sidx_q, sidx_d, bad_q, bad_d;
  logic           done_d, ok_d;
  logic [BW-1:0]  nbits;
  logic [SHW-1:0] aligned;
  logic [DW-1:0]  word_c;
  logic           mpb_c;

  assign rx_s    = sync_q[1];
  assign nbits   = BW'(DW - 1) + BW'(len8) + BW'(mp_fmt);
  assign aligned = sreg_q >> (BW'(SHW) - nbits);
  assign word_c  = len8 ? aligned[DW-1:0] : {1'b0, aligned[DW-2:0]};
  assign mpb_c   = mp_fmt & (len8 ? aligned[DW] : aligned[DW-1]);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bcnt_d  = bcnt_q;
    sreg_d  = sreg_q;
    sidx_d  = sidx_q;
    bad_d   = bad_q;
    done_d  = 1'b0;
    ok_d    = 1'b0;
    if (tick) begin
      unique case (state_q)
        RX_IDLE: if (!rx_s) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
        RX_START: if (cnt_q == CW'(MID)) begin
          cnt_d   = '0;
          bcnt_d  = '0;
          state_d = rx_s ? RX_IDLE : RX_DATA;
        end else cnt_d = cnt_q + 1'b1;
        RX_DATA: if (cnt_q == CW'(OS - 1)) begin
          cnt_d  = '0;
          sreg_d = {rx_s, sreg_q[SHW-1:1]};
          if (bcnt_q == nbits - 1'b1) begin
            state_d = RX_STOP;
            sidx_d  = 1'b0;
            bad_d   = 1'b0;
          end else bcnt_d = bcnt_q + 1'b1;
        end else cnt_d = cnt_q + 1'b1;
        RX_STOP: if (cnt_q == CW'(OS - 1)) begin
          cnt_d = '0;
          if (two_stop && !sidx_q) begin
            sidx_d = 1'b1;
            bad_d  = bad_q | ~rx_s;
          end else begin
            done_d  = 1'b1;
            ok_d    = ~(bad_q | ~rx_s);
            state_d = RX_IDLE;
          end
        end else cnt_d = cnt_q + 1'b1;
        default: state_d = RX_IDLE;
      endcase
    end
    if (!en) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bcnt_q  <= '0;
      sreg_q  <= '0;
      sidx_q  <= 1'b0;
      bad_q   <= 1'b0;
      done    <= 1'b0;
      word    <= '0;
      mpbit   <= 1'b0;
      stop_ok <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rxd};
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bcnt_q  <= bcnt_d;
      sreg_q  <= sreg_d;
      sidx_q  <= sidx_d;
      bad_q   <= bad_d;
      done    <= done_d;
      if (done_d) begin
        word    <= word_c;
        mpbit   <= mpb_c;
        stop_ok <= ok_d;
      end
    end
  end

  // R11: a disabled receiver sits idle from the next cycle on
  a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state_q == RX_IDLE);
  // R2: a character completion is a single-cycle event
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/mpurx_flags.sv
module mpurx_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW-1:0] word,
  input  logic          mpbit,
  input  logic          stop_ok,
  input  logic          mp_fmt,
  input  logic          wake,
  input  logic          rd,
  input  logic          err_clr,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          fe,
  output logic          oe,
  output logic          mpb_last
);
  logic          take, overrun, load;
  logic [DW-1:0] data_d;
  logic          full_d, fe_d, oe_d, mpb_d;

  always_comb begin
    take    = done & ~(mp_fmt & wake & ~mpbit);
    overrun = take & full & ~rd;
    load    = take & ~overrun;
    data_d  = load ? word : data;
    full_d  = load | (full & ~rd);
    fe_d    = (fe & ~err_clr) | (take & ~stop_ok);
    oe_d    = (oe & ~err_clr) | overrun;
    mpb_d   = take ? (mp_fmt & mpbit) : mpb_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data     <= '0;
      full     <= 1'b0;
      fe       <= 1'b0;
      oe       <= 1'b0;
      mpb_last <= 1'b0;
    end else begin
      data     <= data_d;
      full     <= full_d;
      fe       <= fe_d;
      oe       <= oe_d;
      mpb_last <= mpb_d;
    end
  end

  // R5: a filtered character leaves every flag and the held byte alone
  a_r5_drop_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp_fmt && wake && !mpbit && !rd && !err_clr)
      |=> $stable(full) && $stable(fe) && $stable(oe) && $stable(data));
  // R9: overrun flags and keeps the held byte
  a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full && !rd && (!mp_fmt || !wake || mpbit))
      |=> oe && $stable(data));
  // R8: bad stop on an accepted character raises the framing flag
  a_r8_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stop_ok && (!mp_fmt || !wake || mpbit)) |=> fe);
  // R12: a read with no competing arrival empties the holder
  a_r12_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done) |=> !full);
endmodule

// File: rtl/mpurx_ctrl.sv
module mpurx_ctrl
  import mpurx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       mpb_last,
  output logic [7:0] rdata,
  output logic       wake,
  output logic       rxen,
  output logic       len8,
  output logic       two_stop,
  output logic       err_clr
);
  logic [7:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) begin
      ctrl_d         = wdata;
      ctrl_d[CB_MARK] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 8'h10;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata          = ctrl_q;
    rdata[CB_MARK] = mpb_last;
  end

  assign wake     = ctrl_q[CB_WAKE];
  assign rxen     = ctrl_q[CB_RXEN];
  assign len8     = ctrl_q[CB_LEN8];
  assign two_stop = ctrl_q[CB_STOP2];
  assign err_clr  = we & ~wdata[CB_MARK];

  // R7: stored fields read back what was written
  a_r7_write_back: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[7:4] == $past(wdata[7:4])) && (rdata[2:0] == $past(wdata[2:0])));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpurx_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              mp_sel,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rdata,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              err_frame,
  output logic              err_overrun
);
  logic              wake, rxen, len8, two_stop, err_clr, mpb_last;
  logic              done, mpbit, stop_ok;
  logic [DATA_W-1:0] word;

  mpurx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
    .mpb_last(mpb_last), .rdata(ctrl_rdata), .wake(wake), .rxen(rxen),
    .len8(len8), .two_stop(two_stop), .err_clr(err_clr)
  );

  mpurx_sampler #(.OS(OS_RATE), .DW(DATA_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd), .en(rxen),
    .len8(len8), .mp_fmt(mp_sel), .two_stop(two_stop), .done(done),
    .word(word), .mpbit(mpbit), .stop_ok(stop_ok)
  );

  mpurx_flags #(.DW(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .done(done), .word(word), .mpbit(mpbit),
    .stop_ok(stop_ok), .mp_fmt(mp_sel), .wake(wake), .rd(rx_rd),
    .err_clr(err_clr), .data(rx_data), .full(rx_full), .fe(err_frame),
    .oe(err_overrun), .mpb_last(mpb_last)
  );
endmodule

// File: tb/sim_mp_uart_rx.sv
module sim_mp_uart_rx;
  localparam int BIT_CLK = 32;

  logic       clk, rst_n, os_tick, rxd, mp_sel, ctrl_we, rx_rd;
  logic [7:0] ctrl_wdata, ctrl_rdata, rx_data;
  logic       rx_full, err_frame, err_overrun;
  int         errors, checks;
  logic       exp_mark;

  mp_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .mp_sel(mp_sel),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
    .err_frame(err_frame), .err_overrun(err_overrun)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= ~os_tick;

  function automatic logic [7:0] exp_word(input logic [7:0] d, input logic l8);
    return l8 ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic exp_take(input logic mpf, input logic wk, input logic mb);
    return !(mpf && wk && !mb);
  endfunction

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic hold(input logic b);
    rxd = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic mb, input logic l8,
                      input logic mpf, input logic two, input logic stopv);
    hold(1'b0);
    for (int i = 0; i < (l8 ? 8 : 7); i++) hold(d[i]);
    if (mpf) hold(mb);
    if (two) hold(1'b1);
    hold(stopv);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0; checks = 0; exp_mark = 1'b0;
    rst_n = 1'b0; rxd = 1'b1; mp_sel = 1'b0; ctrl_we = 1'b0;
    ctrl_wdata = 8'h00; rx_rd = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl", ctrl_rdata, 8'h10);
    check("R1 full", rx_full, 0);
    check("R1 fe", err_frame, 0);
    check("R1 oe", err_overrun, 0);

    // R7 readback, receiver on, 8 bits, one stop
    wr(8'h4C);
    check("R7 readback", ctrl_rdata, 8'h44);
    wr(8'hB7);
    check("R7 readback2", ctrl_rdata, 8'hB7 & 8'hF7);
    wr(8'h4C);

    // R2 basic 8-bit frame
    send(8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R2 full", rx_full, 1);
    check("R2 data", rx_data, 8'hA5);
    rd();
    check("R12 read clears", rx_full, 0);

    // R4 wakeup armed but format off
    wr(8'hCC);
    send(8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R4 full", rx_full, 1);
    check("R4 data", rx_data, 8'h3C);
    rd();

    // R5 filtered characters
    mp_sel = 1'b1;
    send(8'h77, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R5 full", rx_full, 0);
    check("R5 data", rx_data, 8'h3C);
    send(8'h55, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R5 fe untouched", err_frame, 0);
    check("R5 full2", rx_full, 0);
    send(8'h81, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R5 addr accepted", rx_data, 8'h81);
    check("R7 mark bit", ctrl_rdata[3], 1);
    rd();

    // R6 wakeup off in multiprocessor format
    wr(8'h4C);
    send(8'h12, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R6 full", rx_full, 1);
    check("R6 data", rx_data, 8'h12);
    check("R7 mark zero", ctrl_rdata[3], 0);
    rd();

    // R2 7-bit, two stop bits
    mp_sel = 1'b0;
    wr(8'h49);
    send(8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R2 7bit data", rx_data, 8'h7F);
    rd();
    wr(8'h4C);

    // R3 glitch rejection
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (500) @(negedge clk);
    check("R3 glitch", rx_full, 0);

    // R8 framing, R10 clear
    send(8'h66, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8 fe", err_frame, 1);
    check("R8 data", rx_data, 8'h66);
    rd();
    wr(8'h4C);
    check("R10 keep", err_frame, 1);
    wr(8'h44);
    check("R10 clear fe", err_frame, 0);
    wr(8'h4C);

    // R9 overrun
    send(8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R9 oe", err_overrun, 1);
    check("R9 held", rx_data, 8'h11);
    wr(8'h44);
    check("R10 clear oe", err_overrun, 0);
    wr(8'h4C);
    rd();

    // R11 abort and disabled reception
    rxd = 1'b0;
    repeat (4 * BIT_CLK) @(negedge clk);
    wr(8'h0C);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    check("R11 abort", rx_full, 0);
    send(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R11 disabled", rx_full, 0);
    wr(8'h4C);
    send(8'h99, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R11 recovered", rx_data, 8'h99);
    rd();

    // constrained random
    exp_mark = 1'b0;
    void'($urandom(32'd1234));
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      logic l8, mpf, wk, two, mb, tk;
      logic [7:0] held;
      d = 8'($urandom); l8 = 1'($urandom); mpf = 1'($urandom);
      wk = 1'($urandom); two = 1'($urandom); mb = 1'($urandom);
      held = rx_data;
      mp_sel = mpf;
      wr({wk, 1'b1, 1'b0, 1'b1, 1'b1, l8, 1'b0, two});
      if (n == 0) exp_mark = ctrl_rdata[3];
      send(d, mb, l8, mpf, two, 1'b1);
      tk = exp_take(mpf, wk, mb);
      if (tk) exp_mark = mpf & mb;
      check(tk ? "R6 rand full" : "R5 rand full", rx_full, tk);
      check("R2 rand data", rx_data, tk ? exp_word(d, l8) : held);
      check("R7 rand mark", ctrl_rdata[3], exp_mark);
      check("R8 rand fe", err_frame, 0);
      if (rx_full) rd();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule